// File: doc/BRIEF.md
# Debug-Aware Imprecise Abort Controller

This block decides what happens to each imprecise data abort reported by a buffered write path. An abort can be taken straight away, held until it can be delivered, or dropped after it has been noted in a sticky status flag. The choice depends on whether the core is halted for debug, whether discard mode is active, and an abort mask bit. Outside debug state with the mask clear, an abort produces a one-cycle take request together with its type. With the mask set, the abort is held and delivered once the mask clears.

When debug state is entered, the barrier that drains pending writes can flush out one last abort. That abort is held, and it also sets the sticky flag. One clock edge after that barrier completes, the block enters discard mode. From then on, every abort sets only the sticky flag, and its type is lost. An abort already held when discard mode begins is never replaced. Leaving debug state clears discard mode, and the held abort is then delivered, subject to the mask. A read of the status register clears the sticky flag.

Top module: `iabt_ctrl`

## Requirements
- R1: Reset leaves the take request, sticky flag and discard flag low and leaves no abort held. After reset, clearing the mask produces no take request.
- R2: An abort with the core outside debug state and the mask clear raises `take_o` for exactly one cycle, starting at the next clock edge. `take_kind_o` carries the abort's type, and the sticky flag is not set.
- R3: An abort outside debug state with the mask set is held. It is taken at the first clock edge at which the mask is sampled clear, and `take_kind_o` carries its type.
- R4: An abort in debug state with discard mode off is held and is not taken while debug state lasts. It also sets the sticky flag at the next edge.
- R5: `discard_o` rises at the clock edge after a barrier completes in debug state. An abort arriving in the same cycle as that barrier is still held.
- R6: An abort in discard mode sets the sticky flag and leaves nothing held. With no earlier abort held, no take request follows debug exit.
- R7: An abort held before discard mode began is not overwritten by aborts that arrive in discard mode. It is delivered with its original type after debug exit.
- R8: A debug exit strobe clears `discard_o` at the next edge and leaves the sticky flag unchanged. A held abort is taken one edge later if the mask is clear.
- R9: If the mask is set when debug state is left, the held abort stays pending and is taken at the first edge at which the mask is sampled clear.
- R10: A status read clears the sticky flag at the next edge. An abort in debug state in the same cycle as the read wins, and the flag stays set.
- R11: While an abort is held and not being taken, a new abort is dropped, and the held type is the one delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| abort_i | input | 1 | One-cycle imprecise abort indication from the write path |
| abort_kind_i | input | KIND_W | Type of the abort, valid with `abort_i` |
| dbg_enter_i | input | 1 | Strobe: core enters debug state |
| dbg_exit_i | input | 1 | Strobe: core leaves debug state (takes priority over an entry strobe in the same cycle) |
| barrier_done_i | input | 1 | Strobe: a data memory barrier has completed |
| abort_mask_i | input | 1 | Abort mask; when high, aborts are not taken |
| stat_rd_i | input | 1 | Strobe: the debug status register is being read |
| take_o | output | 1 | One-cycle request to take an imprecise abort |
| take_kind_o | output | KIND_W | Type of the abort being taken, valid with `take_o` |
| sticky_o | output | 1 | Sticky flag: an imprecise abort occurred in debug state |
| discard_o | output | 1 | Discard mode: aborts are being dropped |

## Verification
The assertions assume that the debug entry, exit, barrier and read inputs are single-cycle strobes sampled on the clock. They also assume that an abort and its type are presented together for one cycle. The stimulus applies every input on the falling edge and holds each one for exactly one rising edge. This keeps each vector a clean single-cycle strobe. It also means the registered debug state always reflects the previous vector, which is the state the expected values in the table are written against.

// File: rtl/iabt_pkg.sv
package iabt_pkg;

  // Debug mode state shared between the mode tracker and its consumers.
  typedef struct packed {
    logic in_dbg;
    logic discard;
  } iabt_mode_t;

endpackage

// File: rtl/iabt_rst_sync.sv
module iabt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/iabt_mode.sv
module iabt_mode
  import iabt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enter_i,
  input  logic       exit_i,
  input  logic       barrier_i,
  output iabt_mode_t mode_o
);

  logic in_dbg_q, in_dbg_d;
  logic discard_q, discard_d;

  always_comb begin
    in_dbg_d  = in_dbg_q;
    discard_d = discard_q;
    if (exit_i) begin
      in_dbg_d  = 1'b0;
      discard_d = 1'b0;
    end else begin
      if (enter_i) in_dbg_d = 1'b1;
      if (in_dbg_q && barrier_i) discard_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_dbg_q  <= 1'b0;
      discard_q <= 1'b0;
    end else begin
      in_dbg_q  <= in_dbg_d;
      discard_q <= discard_d;
    end
  end

  assign mode_o.in_dbg  = in_dbg_q;
  assign mode_o.discard = discard_q;

  // R8: an exit strobe always leaves discard mode off
  a_r8_exit_clears_discard: assert property (@(posedge clk) disable iff (!rst_n)
    exit_i |=> !discard_q);

  // R5: discard mode never exists outside debug state
  a_r5_discard_in_dbg: assert property (@(posedge clk) disable iff (!rst_n)
    discard_q |-> in_dbg_q);

  // R5: a barrier in debug state without exit turns discard mode on
  a_r5_barrier_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (in_dbg_q && barrier_i && !exit_i) |=> discard_q);

endmodule

// File: rtl/iabt_sticky.sv
module iabt_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic in_dbg_i,
  input  logic abort_i,
  input  logic rd_i,
  output logic sticky_o
);

  logic sticky_q, sticky_d;
  logic set_ev;

  always_comb begin
    set_ev   = in_dbg_i && abort_i;
    sticky_d = sticky_q;
    if (set_ev)    sticky_d = 1'b1;
    else if (rd_i) sticky_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sticky_q <= 1'b0;
    else        sticky_q <= sticky_d;
  end

  assign sticky_o = sticky_q;

  // R10: an abort in debug state wins over a simultaneous read
  a_r10_abort_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (in_dbg_i && abort_i && rd_i) |=> sticky_q);

  // R10: a read with no debug abort leaves the flag clear
  a_r10_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && !(in_dbg_i && abort_i)) |=> !sticky_q);

  // R2: outside debug state the flag never rises
  a_r2_no_sticky_outside: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_dbg_i && !sticky_q) |=> !sticky_q);

endmodule

// File: rtl/iabt_latch.sv
module iabt_latch #(
  parameter int KIND_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              abort_i,
  input  logic [KIND_W-1:0] kind_i,
  input  logic              in_dbg_i,
  input  logic              discard_i,
  input  logic              mask_i,
  output logic              take_o,
  output logic [KIND_W-1:0] take_kind_o
);

  logic              valid_q, valid_d;
  logic [KIND_W-1:0] held_q, held_d;
  logic              held_en;
  logic              take_q, take_d;
  logic [KIND_W-1:0] out_q, out_d;
  logic              deliver;
  logic              accept;

  always_comb begin
    deliver = !in_dbg_i && !mask_i;
    accept  = abort_i && !discard_i;
    valid_d = valid_q;
    held_d  = held_q;
    held_en = 1'b0;
    take_d  = 1'b0;
    out_d   = out_q;
    if (valid_q && deliver) begin
      take_d  = 1'b1;
      out_d   = held_q;
      valid_d = accept;
      held_en = accept;
      held_d  = kind_i;
    end else if (!valid_q && accept) begin
      if (deliver) begin
        take_d = 1'b1;
        out_d  = kind_i;
      end else begin
        valid_d = 1'b1;
        held_en = 1'b1;
        held_d  = kind_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      held_q  <= '0;
      take_q  <= 1'b0;
      out_q   <= '0;
    end else begin
      valid_q <= valid_d;
      take_q  <= take_d;
      if (held_en) held_q <= held_d;
      if (take_d)  out_q  <= out_d;
    end
  end

  assign take_o      = take_q;
  assign take_kind_o = out_q;

  // R4: nothing is taken while in debug state
  a_r4_no_take_in_dbg: assert property (@(posedge clk) disable iff (!rst_n)
    in_dbg_i |=> !take_q);

  // R3: a set mask blocks every take
  a_r3_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    mask_i |=> !take_q);

  // R7: a held abort survives discard mode unchanged
  a_r7_held_in_discard: assert property (@(posedge clk) disable iff (!rst_n)
    (discard_i && valid_q) |=> (valid_q && $stable(held_q)));

  // R2: a take always has a held or incoming abort behind it
  a_r2_take_has_source: assert property (@(posedge clk) disable iff (!rst_n)
    take_q |-> $past(valid_q || abort_i));

endmodule

// File: rtl/iabt_ctrl.sv
module iabt_ctrl
  import iabt_pkg::*;
#(
  parameter int KIND_W    = 4,
  parameter int RST_STAGE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              abort_i,
  input  logic [KIND_W-1:0] abort_kind_i,
  input  logic              dbg_enter_i,
  input  logic              dbg_exit_i,
  input  logic              barrier_done_i,
  input  logic              abort_mask_i,
  input  logic              stat_rd_i,
  output logic              take_o,
  output logic [KIND_W-1:0] take_kind_o,
  output logic              sticky_o,
  output logic              discard_o
);

  logic       rst_n_s;
  iabt_mode_t mode;

  iabt_rst_sync #(.STAGES(RST_STAGE)) i_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  iabt_mode i_mode (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .enter_i   (dbg_enter_i),
    .exit_i    (dbg_exit_i),
    .barrier_i (barrier_done_i),
    .mode_o    (mode)
  );

  iabt_sticky i_sticky (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .in_dbg_i (mode.in_dbg),
    .abort_i  (abort_i),
    .rd_i     (stat_rd_i),
    .sticky_o (sticky_o)
  );

  iabt_latch #(.KIND_W(KIND_W)) i_latch (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .abort_i     (abort_i),
    .kind_i      (abort_kind_i),
    .in_dbg_i    (mode.in_dbg),
    .discard_i   (mode.discard),
    .mask_i      (abort_mask_i),
    .take_o      (take_o),
    .take_kind_o (take_kind_o)
  );

  assign discard_o = mode.discard;

  // R1: while reset is held, the outputs stay quiet
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n_s |-> (!take_o && !sticky_o && !discard_o));

  // R6: an abort in discard mode never produces a take at the next edge
  a_r6_discard_no_take: assert property (@(posedge clk) disable iff (!rst_n_s)
    (discard_o && abort_i) |=> !take_o);

endmodule

// File: tb/test_iabt_ctrl.sv
module test_iabt_ctrl;

  localparam int KW = 4;

  typedef struct packed {
    logic [3:0]    req;
    logic          en, ex, bar, msk, rd, ab;
    logic [KW-1:0] kd;
    logic          et;
    logic [KW-1:0] ek;
    logic          es, ed;
  } vec_t;

  // req | en ex bar msk rd ab | kind | exp take | exp kind | exp sticky, discard
  localparam int NV = 34;
  localparam vec_t VEC [NV] = '{
    21'b0010_000001_0011_1_0011_00, // R2 immediate take
    21'b0010_000000_0000_0_0000_00, // R2 single cycle
    21'b0011_000101_0101_0_0000_00, // R3 held under mask
    21'b0011_000100_0000_0_0000_00, // R3
    21'b0011_000000_0000_1_0101_00, // R3 taken when mask clears
    21'b0011_000000_0000_0_0000_00, // R3
    21'b1011_000101_0110_0_0000_00, // R11 first held
    21'b1011_000101_0111_0_0000_00, // R11 second dropped
    21'b1011_000000_0000_1_0110_00, // R11 first delivered
    21'b1011_000000_0000_0_0000_00, // R11
    21'b0100_100000_0000_0_0000_00, // R4 enter debug
    21'b0100_000001_1001_0_0000_10, // R4 held, sticky
    21'b0101_001000_0000_0_0000_11, // R5 barrier -> discard
    21'b1010_000010_0000_0_0000_01, // R10 read clears
    21'b0110_000001_0010_0_0000_11, // R6 discard-mode abort
    21'b1010_000011_0100_0_0000_11, // R10 abort wins over read
    21'b1010_000010_0000_0_0000_01, // R10
    21'b1000_010000_0000_0_0000_00, // R8 exit clears discard
    21'b0111_000000_0000_1_1001_00, // R7 original kind delivered
    21'b0010_000000_0000_0_0000_00, // R2
    21'b0100_100000_0000_0_0000_00, // R4 enter
    21'b0101_001001_1010_0_0000_11, // R5 abort with barrier still held
    21'b1001_010100_0000_0_0000_10, // R9 exit with mask set
    21'b1001_000100_0000_0_0000_10, // R9 pending
    21'b1001_000100_0000_0_0000_10, // R9 pending
    21'b1001_000000_0000_1_1010_10, // R9 taken
    21'b1001_000000_0000_0_0000_10, // R8 sticky survives exit
    21'b1010_000010_0000_0_0000_00, // R10
    21'b0110_100000_0000_0_0000_00, // R6 enter
    21'b0110_001000_0000_0_0000_01, // R6 barrier
    21'b0110_000001_0001_0_0000_11, // R6 abort discarded
    21'b1000_010000_0000_0_0000_10, // R8 exit
    21'b0110_000000_0000_0_0000_10, // R6 nothing taken
    21'b1010_000010_0000_0_0000_00  // R10
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic          abort_i, dbg_enter_i, dbg_exit_i, barrier_done_i, abort_mask_i, stat_rd_i;
  logic [KW-1:0] abort_kind_i;
  logic          take_o, sticky_o, discard_o;
  logic [KW-1:0] take_kind_o;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;

  always #5 clk = ~clk;

  iabt_ctrl #(.KIND_W(KW)) i_iabt_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .abort_i        (abort_i),
    .abort_kind_i   (abort_kind_i),
    .dbg_enter_i    (dbg_enter_i),
    .dbg_exit_i     (dbg_exit_i),
    .barrier_done_i (barrier_done_i),
    .abort_mask_i   (abort_mask_i),
    .stat_rd_i      (stat_rd_i),
    .take_o         (take_o),
    .take_kind_o    (take_kind_o),
    .sticky_o       (sticky_o),
    .discard_o      (discard_o)
  );

  task automatic check(input string tag, input logic et, input logic [KW-1:0] ek,
                       input logic es, input logic ed);
    logic [KW+2:0] act, exp;
    act = {take_o, take_o ? take_kind_o : {KW{1'b0}}, sticky_o, discard_o};
    exp = {et, et ? ek : {KW{1'b0}}, es, ed};
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual take/kind/sticky/discard %b expected %b", tag, act, exp);
    end
  endtask

  task automatic drive(input logic en, ex, bar, msk, rd, ab, input logic [KW-1:0] kd);
    dbg_enter_i = en; dbg_exit_i = ex; barrier_done_i = bar;
    abort_mask_i = msk; stat_rd_i = rd; abort_i = ab; abort_kind_i = kd;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    drive(0, 0, 0, 0, 0, 0, '0);
    repeat (3) @(negedge clk);
    check("R1 reset", 0, '0, 0, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 after release", 0, '0, 0, 0);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VEC[i];
      drive(v.en, v.ex, v.bar, v.msk, v.rd, v.ab, v.kd);
      @(negedge clk);
      check($sformatf("R%0d vector %0d", v.req, i), v.et, v.ek, v.es, v.ed);
    end

    // R1: reset mid-run drops a held abort, sticky and discard state
    drive(0, 0, 0, 1, 0, 1, 4'hC);
    @(negedge clk);
    drive(1, 0, 0, 1, 0, 0, '0);
    @(negedge clk);
    drive(0, 0, 1, 1, 0, 1, 4'hD);
    @(negedge clk);
    drive(0, 0, 0, 1, 0, 0, '0);
    @(negedge clk);
    check("R1 before reset", 0, '0, 1, 1);
    rst_n = 1'b0;
    #1;
    check("R1 async clear", 0, '0, 0, 0);
    @(negedge clk);
    rst_n = 1'b1;
    drive(0, 0, 0, 0, 0, 0, '0);
    repeat (3) @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R1 nothing held", 0, '0, 0, 0);
    end

    // R2: back-to-back aborts each give their own pulse
    drive(0, 0, 0, 0, 0, 1, 4'h1);
    @(negedge clk);
    check("R2 first", 1, 4'h1, 0, 0);
    drive(0, 0, 0, 0, 0, 1, 4'h2);
    @(negedge clk);
    check("R2 second", 1, 4'h2, 0, 0);
    drive(0, 0, 0, 0, 0, 0, '0);
    @(negedge clk);
    check("R2 end", 0, '0, 0, 0);

    finish_run();
  end

endmodule